// File: doc/BRIEF.md
# Variable-Length Line Delay Memory

This block is a single-line buffer of 5120 words by 8 bits with two independent sides. The write side stores one word per enabled write-clock edge at a write address that steps upward. The read side hands words back in the same order, one per enabled read-clock edge. Neither side reports fullness or emptiness, and neither side ever pushes back on the other. The distance between input and output is set only by when each side's address is cleared, so the buffer serves as a delay line of selectable length. A typical use places it between two scan lines of an image stream to delay one line relative to the next.

Both sides use active-low control. Each side has an enable and a synchronous address clear. An incoming word is accepted on every edge where the write enable is low. Nothing is ever refused, so the write side has no ready signal and no back-pressure. On the read side, a high-impedance bus is stood in for by a registered valid flag. When `rvalid` is high, `rdata` carries a word. When `rvalid` is low, the bus counts as undriven and `rdata` must be ignored. The downstream consumer cannot stall the read side. It can only stop reads by raising the read enable.

Top module: `ldm_line_delay`

## Requirements
- R1: The storage holds DEPTH words (default 5120) of DW bits (default 8). On a rising `wclk` edge with `wen_n` low, the word on `wdata` is accepted for the current write address and the write address steps by one.
- R2: On a rising `wclk` edge with `wen_n` high and `wrst_n` high, no word is accepted and the write address is unchanged. The next enabled write continues at the following address with no gap.
- R3: On a rising `wclk` edge with `wrst_n` low, the write address is cleared. The clear outranks the enable. If `wen_n` is also low, that edge writes address 0 and the next write goes to address 1.
- R4: On a rising `rclk` edge with `rren_n` low, the word at the current read address is registered onto `rdata`, `rvalid` goes high after that edge, and the read address steps by one.
- R5: On a rising `rclk` edge with `ren_n` high, `rvalid` goes low after that edge. If `rrst_n` is also high, the read address is unchanged.
- R6: On a rising `rclk` edge with `rrst_n` low, the read address is cleared, and the clear outranks the enable. Each such edge with `ren_n` low outputs word 0. The first enabled read after the clear is released returns word 1.
- R7: Both addresses wrap from DEPTH-1 to 0 when they step past the last word.
- R8: A word accepted at write edge k is committed to storage at write edge k+1, whatever the enable is at k+1. A read at an edge no later than k+1 returns the earlier contents of that address. A read after edge k+1 returns the new word.
- R9: If the write address is cleared at edge 0 and the read address at edge N (N at least 3), with both enables held low, then the word read at edge N+i is the word written at edge i.
- R10: If both addresses are cleared at the same edge, the delay is one full line of DEPTH cycles. The word read at each address is the one written there one line earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Synchronous write-address clear, active low |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | DW | Word to store |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Synchronous read-address clear, active low |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | DW | Word read; meaningful only while `rvalid` is high |
| rvalid | output | 1 | High while the read bus counts as driven |

## Verification
The bench aims at the commit pipeline by running delays of one and two cycles over a line of known contents. A design that commits too early or too late returns a new word where the old word is due, or the reverse. It holds each clear for several cycles with the enable asserted. A design that lets the enable win would drift past word 0, and one that misplaces the first read after release would skip word 1 or repeat word 0. A full-line run and long random runs with gaps and stray clears cover the wrap at the last address and the holding of each address, where an off-by-one shows up as a shifted stream.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  // What a pointer does on its clock edge, decoded from its active-low pins.
  typedef enum logic [1:0] {
    PTR_HOLD    = 2'd0,
    PTR_ADV     = 2'd1,
    PTR_CLR     = 2'd2,
    PTR_CLR_ADV = 2'd3
  } ptr_op_e;

  function automatic ptr_op_e decode_op(input logic clr_n, input logic en_n);
    ptr_op_e op;
    unique case ({clr_n, en_n})
      2'b00:   op = PTR_CLR_ADV;
      2'b01:   op = PTR_CLR;
      2'b10:   op = PTR_ADV;
      default: op = PTR_HOLD;
    endcase
    return op;
  endfunction

  function automatic logic op_clears(input ptr_op_e op);
    return (op == PTR_CLR) || (op == PTR_CLR_ADV);
  endfunction

  function automatic logic op_moves(input ptr_op_e op);
    return (op == PTR_ADV) || (op == PTR_CLR_ADV);
  endfunction

endpackage

// File: rtl/ldm_ptr.sv
module ldm_ptr #(
  parameter int DEPTH = 5120,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          en_n,
  output logic [AW-1:0] acc_addr,
  output logic          acc_go,
  output logic [AW-1:0] ptr
);
  import ldm_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  ptr_op_e       op;
  logic [AW-1:0] step_addr;

  // The address used this edge: a clear beats the stored pointer.
  always_comb begin
    op        = decode_op(clr_n, en_n);
    acc_addr  = op_clears(op) ? '0 : ptr;
    acc_go    = op_moves(op);
    step_addr = (acc_addr == LAST) ? '0 : acc_addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    ptr <= acc_go ? step_addr : acc_addr;
  end

endmodule

// File: rtl/ldm_wr_stage.sv
module ldm_wr_stage #(
  parameter int DW = 8,
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          go,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cm_vld,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);
  // Hold the accepted word for one edge; the array commits it on the next.
  always_ff @(posedge clk) begin
    cm_vld <= go;
    if (go) begin
      cm_addr <= addr;
      cm_data <= data;
    end
  end

endmodule

// File: rtl/ldm_store.sv
module ldm_store #(
  parameter int DEPTH = 5120,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          cm_vld,
  input  logic [AW-1:0] cm_addr,
  input  logic [DW-1:0] cm_data,
  input  logic          rclk,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (cm_vld) mem[cm_addr] <= cm_data;
  end

  // Registered read; output holds while reads are disabled.
  always_ff @(posedge rclk) begin
    if (rd_go) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/ldm_rd_flag.sv
module ldm_rd_flag (
  input  logic clk,
  input  logic go,
  output logic drive
);
  // Stands in for the output-buffer enable of a tri-state bus.
  always_ff @(posedge clk) begin
    drive <= go;
  end

endmodule

// File: rtl/ldm_line_delay.sv
module ldm_line_delay #(
  parameter int DEPTH = 5120,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen_n,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [AW-1:0] wr_acc, wr_ptr;
  logic          wr_go;
  logic [AW-1:0] rd_acc, rd_ptr;
  logic          rd_go;
  logic          cm_vld;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  ldm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk(wclk), .clr_n(wrst_n), .en_n(wen_n),
    .acc_addr(wr_acc), .acc_go(wr_go), .ptr(wr_ptr)
  );

  ldm_wr_stage #(.DW(DW), .AW(AW)) u_wstage (
    .clk(wclk), .go(wr_go), .addr(wr_acc), .data(wdata),
    .cm_vld(cm_vld), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  ldm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk(rclk), .clr_n(rrst_n), .en_n(ren_n),
    .acc_addr(rd_acc), .acc_go(rd_go), .ptr(rd_ptr)
  );

  ldm_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .wclk(wclk), .cm_vld(cm_vld), .cm_addr(cm_addr), .cm_data(cm_data),
    .rclk(rclk), .rd_go(rd_go), .rd_addr(rd_acc), .rd_q(rdata)
  );

  ldm_rd_flag u_rflag (
    .clk(rclk), .go(rd_go), .drive(rvalid)
  );

endmodule

// File: rtl/ldm_line_delay_chk.sv
module ldm_line_delay_chk #(
  parameter int DEPTH = 5120,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wen_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          ren_n,
  input logic          rvalid,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic          cm_vld
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // Each side counts as out of reset once its address has been cleared.
  logic w_armed = 1'b0;
  logic r_armed = 1'b0;
  always_ff @(posedge wclk) if (!wrst_n) w_armed <= 1'b1;
  always_ff @(posedge rclk) if (!rrst_n) r_armed <= 1'b1;

  // R2
  wr_hold_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (wen_n && wrst_n) |=> $stable(wr_ptr));

  // R3
  wr_clr_idle_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (!wrst_n && wen_n) |=> (wr_ptr == '0));

  // R3
  wr_clr_go_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (!wrst_n && !wen_n) |=> (wr_ptr == AW'(1)));

  // R4
  rd_drive_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    !ren_n |=> rvalid);

  // R5
  rd_float_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    ren_n |=> !rvalid);

  // R5
  rd_hold_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    (ren_n && rrst_n) |=> $stable(rd_ptr));

  // R6
  rd_clr_go_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    (!rrst_n && !ren_n) |=> (rd_ptr == AW'(1)));

  // R7
  wr_wrap_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (wrst_n && !wen_n && wr_ptr == LAST) |=> (wr_ptr == '0));

  // R7
  rd_wrap_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    (rrst_n && !ren_n && rd_ptr == LAST) |=> (rd_ptr == '0));

  // R8
  commit_follow_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    !wen_n |=> cm_vld);

  // R8
  commit_idle_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    wen_n |=> !cm_vld);

endmodule

bind ldm_line_delay ldm_line_delay_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wen_n(wen_n),
  .rclk(rclk), .rrst_n(rrst_n), .ren_n(ren_n),
  .rvalid(rvalid), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cm_vld(cm_vld)
);

// File: tb/ldm_line_delay_test.sv
module ldm_line_delay_test;
  localparam int DEPTH = 5120;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          wrst_n = 1'b1, wen_n = 1'b1, rrst_n = 1'b1, ren_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  ldm_line_delay #(.DEPTH(DEPTH), .DW(DW)) uut (
    .wclk(clk), .wrst_n(wrst_n), .wen_n(wen_n), .wdata(wdata),
    .rclk(clk), .rrst_n(rrst_n), .ren_n(ren_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  // Reference model built from the requirements.
  logic [DW-1:0] mm [DEPTH];
  bit            kn [DEPTH];
  int            wp = 0, rp = 0, pa = 0;
  bit            pv = 0, rwrap = 0;
  logic [DW-1:0] pd = '0;

  function automatic int nxt(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock cycle: drive at the falling edge, predict, sample at the next falling edge.
  task automatic cycle(input bit wr, input bit we, input logic [DW-1:0] wd,
                       input bit rr, input bit re, input string tag);
    bit            ev, ek;
    logic [DW-1:0] eq;
    string         dtag;
    int            ra, wa;
    wrst_n = wr; wen_n = we; wdata = wd; rrst_n = rr; ren_n = re;
    ev = 0; ek = 0; eq = '0; dtag = tag;
    if (!re) begin
      ra = !rr ? 0 : rp;
      if (!rr) dtag = "R6";
      else if (rwrap) dtag = "R7";
      ev = 1; ek = kn[ra]; eq = mm[ra];
      rwrap = (ra == DEPTH - 1);
      rp = nxt(ra);
    end else if (!rr) begin
      rp = 0; rwrap = 0;
    end
    if (pv) begin mm[pa] = pd; kn[pa] = 1; end
    wa = !wr ? 0 : wp;
    if (!we) begin pv = 1; pa = wa; pd = wd; wp = nxt(wa); end
    else begin pv = 0; wp = wa; end
    @(posedge clk);
    @(negedge clk);
    check(rvalid == ev, ev ? "R4" : "R5", int'(rvalid), int'(ev));
    if (ev && ek) check(rdata == eq, dtag, int'(rdata), int'(eq));
  endtask

  task automatic delay_run(input int n, input int len, input string tag);
    for (int i = 0; i < len; i++)
      cycle(i != 0, 0, DW'($urandom_range(255)), i != n, i < n, tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1729);
    @(negedge clk);
    // Reset state: both clears with enables high; bus undriven (R5).
    cycle(0, 1, '0, 0, 1, "R5");
    cycle(0, 1, '0, 0, 1, "R5");
    // Basic stream with the minimum offset (R1), then a longer offset (R9).
    delay_run(3, 64, "R1");
    delay_run(7, 64, "R9");
    // Write gaps: the address holds while disabled (R2).
    for (int i = 0; i < 40; i++)
      cycle(i != 0, (i != 0) && ($urandom_range(1) == 1), DW'($urandom_range(255)), 1, 1, "R2");
    for (int i = 0; i < 30; i++)
      cycle(1, 1, '0, i != 0, 0, "R2");
    // Held write clear with enable: address 0 is rewritten each edge (R3).
    for (int i = 0; i < 20; i++)
      cycle(i >= 4, 0, DW'(8'h40 + i), i != 10, i < 10, "R3");
    // Held read clear with enable: word 0 repeats, then word 1 (R6).
    for (int i = 0; i < 12; i++)
      cycle(1, 1, '0, i >= 4, 0, "R6");
    // Full-line delay across two wraps (R10, R7).
    for (int i = 0; i < 2 * DEPTH + 20; i++)
      cycle(i != 0, 0, DW'($urandom_range(255)), i != 0, 0, "R10");
    // Commit pipeline: offsets one and two over known contents (R8).
    delay_run(1, 24, "R8");
    delay_run(2, 24, "R8");
    // Random traffic with gaps and stray clears.
    for (int i = 0; i < 15000; i++)
      cycle($urandom_range(199) != 0, $urandom_range(9) < 3, DW'($urandom_range(255)),
            $urandom_range(199) != 0, $urandom_range(9) < 3, "R4");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule